// File: doc/BRIEF.md
# Extended-Immediate Instruction Decoder

This block sits between the instruction fetch stream and the execute stage of a 32-bit RISC-V style core. It takes one 32-bit word per handshake. It keeps its own program counter, which is a dedicated register. For each instruction it presents the opcode, the register indices, `funct3`, a sign-extended 32-bit immediate, the instruction's address and a branch target. The immediate is decoded in the usual way for each instruction format.

The block adds one non-standard rule. For register-immediate arithmetic, load, store and conditional branch instructions, a raw 12-bit immediate field equal to `0x800` does not mean -2048. It means that the next stream word is the full 32-bit immediate. That word is consumed as data and is never decoded as an instruction. The pair produces one output beat with `out_ext` set, and the PC advances by 8 instead of 4.

Both stream sides use valid/ready. An input word is taken in a cycle where `in_valid` and `in_ready` are both high. An output beat is taken in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output holds every field stable and no new word is accepted. A first word that carries the sentinel is kept internally until its extension word arrives. Gaps in the input and stalls at the output can occur in between without losing it.

Top module: `ximm_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, drops any first word still waiting for its extension word, and loads the PC with `START_PC` (bit 0 forced to 0). The first instruction accepted after reset reports that PC.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A word is consumed only in a cycle where `in_valid` and `in_ready` are both high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields stay unchanged.
- R4: Outside the extension case, the immediate is sign-extended to 32 bits as follows:
  - I format (opcodes 0010011, 0000011, 1100111): instr[31:20].
  - S format (0100011): {instr[31:25], instr[11:7]}.
  - B format (1100011): {instr[31], instr[7], instr[30:25], instr[11:8], 0}.
  - U format (0110111, 0010111): instr[31:12] followed by 12 zeros.
  - J format (1101111): {instr[31], instr[19:12], instr[20], instr[30:21], 0}.
  - Any other opcode: the immediate is 0.
- R5: The sentinel is a raw 12-bit field equal to 0x800. The field is read as follows:
  - Opcodes 0010011 and 0000011: instr[31:20].
  - Opcode 0100011: {instr[31:25], instr[11:7]}.
  - Opcode 1100011: {instr[31], instr[7], instr[30:25], instr[11:8]}.
  - An output built from a sentinel instruction has `out_ext` = 1. Every other output has `out_ext` = 0.
- R6: After a sentinel instruction, the next accepted word becomes `out_imm` unchanged. Exactly one output beat is produced for the pair, carrying the first word's fields, and the second word is never decoded.
- R7: `out_pc` is the address of the instruction's first word. The PC advances by 4 after a normal instruction and by 8 after a sentinel pair.
- R8: `out_target` equals `out_pc + out_imm` with bit 0 forced to 0. This includes branches with a 32-bit extended displacement.
- R9: Opcodes outside the four eligible classes (for example 0110111, 1100111 and 0110011) that contain 0x800 in instr[31:20] are decoded normally and never take an extension word.
- R10: A pending sentinel instruction survives any number of cycles with `in_valid` low or with the output stalled, and still pairs with the next accepted word.
- R11: `out_opcode` = instr[6:0], `out_rd` = instr[11:7], `out_funct3` = instr[14:12], `out_rs1` = instr[19:15] and `out_rs2` = instr[24:20], all taken from the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Instruction or extension word |
| out_valid | output | 1 | Decoded beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_pc | output | 32 | Address of the instruction |
| out_opcode | output | 7 | Opcode field |
| out_rd | output | 5 | Destination register index |
| out_rs1 | output | 5 | First source register index |
| out_rs2 | output | 5 | Second source register index |
| out_funct3 | output | 3 | Minor opcode field |
| out_imm | output | 32 | Sign-extended or extended immediate |
| out_target | output | 32 | out_pc + out_imm, bit 0 cleared |
| out_ext | output | 1 | Immediate came from an extension word |

## Verification
- **Normal instruction:** its output beat becomes visible right after the clock edge that accepts the word, so it is due one cycle later.
- **Sentinel pair:** nothing appears after the first word. The single beat appears after the edge that accepts the extension word.
- **Back-pressure and PC:** `in_ready` follows the output register in the same cycle. The PC change is due at the edge of the accepting handshake.
- **How the bench keeps to this:** its reference model advances on the same edge as the design, using only port values. The bench compares `in_ready`, `out_valid` and every output field at the falling edge of each clock. A result that arrives a cycle early or a cycle late therefore shows up as a mismatch.

// File: rtl/ximm_pkg.sv
package ximm_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RAW_W    = 12;
  localparam logic [RAW_W-1:0] SENTINEL = 12'h800;

  localparam logic [6:0] OPC_ALUI   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef struct packed {
    logic [6:0]        opcode;
    logic [4:0]        rd;
    logic [4:0]        rs1;
    logic [4:0]        rs2;
    logic [2:0]        funct3;
    logic [WORD_W-1:0] imm;
    logic              sentinel;
  } dec_t;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXTWORD = 1'b1
  } seq_state_t;

endpackage

// File: rtl/ximm_imm_extract.sv
module ximm_imm_extract
  import ximm_pkg::*;
#(
  parameter bit EXT_ENABLE = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);

  logic [6:0]       opc;
  logic [RAW_W-1:0] raw_i;
  logic [RAW_W-1:0] raw_s;
  logic [RAW_W-1:0] raw_b;
  logic [RAW_W-1:0] raw_sel;
  logic             eligible;
  logic [WORD_W-1:0] imm_std;

  assign opc   = word[6:0];
  assign raw_i = word[31:20];
  assign raw_s = {word[31:25], word[11:7]};
  assign raw_b = {word[31], word[7], word[30:25], word[11:8]};

  always_comb begin
    unique case (opc)
      OPC_ALUI, OPC_LOAD, OPC_JALR:
        imm_std = {{(WORD_W-RAW_W){raw_i[RAW_W-1]}}, raw_i};
      OPC_STORE:
        imm_std = {{(WORD_W-RAW_W){raw_s[RAW_W-1]}}, raw_s};
      OPC_BRANCH:
        imm_std = {{(WORD_W-RAW_W-1){raw_b[RAW_W-1]}}, raw_b, 1'b0};
      OPC_LUI, OPC_AUIPC:
        imm_std = {word[31:12], 12'h000};
      OPC_JAL:
        imm_std = {{11{word[31]}}, word[31], word[19:12], word[20], word[30:21], 1'b0};
      default:
        imm_std = '0;
    endcase
  end

  always_comb begin
    eligible = 1'b1;
    raw_sel  = raw_i;
    unique case (opc)
      OPC_ALUI, OPC_LOAD: raw_sel = raw_i;
      OPC_STORE:          raw_sel = raw_s;
      OPC_BRANCH:         raw_sel = raw_b;
      default:            eligible = 1'b0;
    endcase
  end

  generate
    if (EXT_ENABLE) begin : g_ext
      assign dec.sentinel = eligible && (raw_sel == SENTINEL);
    end else begin : g_noext
      assign dec.sentinel = 1'b0;
    end
  endgenerate

  assign dec.opcode = opc;
  assign dec.rd     = word[11:7];
  assign dec.funct3 = word[14:12];
  assign dec.rs1    = word[19:15];
  assign dec.rs2    = word[24:20];
  assign dec.imm    = imm_std;

endmodule

// File: rtl/ximm_pc_reg.sv
module ximm_pc_reg
  import ximm_pkg::*;
#(
  parameter logic [WORD_W-1:0] START_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_one,
  input  logic              step_two,
  output logic [WORD_W-1:0] pc
);

  localparam logic [WORD_W-1:0] START_ALIGNED = {START_PC[WORD_W-1:1], 1'b0};
  localparam logic [WORD_W-1:0] STRIDE        = WORD_W'(4);

  logic [WORD_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= START_ALIGNED;
    else if (step_two)
      pc_q <= pc_q + (STRIDE << 1);
    else if (step_one)
      pc_q <= pc_q + STRIDE;
  end

  assign pc = pc_q;

  assert_pc_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    step_one |=> pc_q == $past(pc_q) + 32'd4);
  assert_pc_double_step_R7: assert property (@(posedge clk) disable iff (rst)
    step_two |=> pc_q == $past(pc_q) + 32'd8);
  assert_pc_steps_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(step_one && step_two));

endmodule

// File: rtl/ximm_sequencer.sv
module ximm_sequencer
  import ximm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  dec_t              dec,
  input  logic [WORD_W-1:0] pc,
  output logic              step_one,
  output logic              step_two,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_pc,
  output dec_t              out_dec,
  output logic [WORD_W-1:0] out_target,
  output logic              out_ext
);

  seq_state_t        state_q;
  dec_t              hold_q;
  logic              valid_q;
  logic              ext_q;
  dec_t              beat_q;
  logic [WORD_W-1:0] pc_out_q;
  logic [WORD_W-1:0] target_q;
  logic              fire;
  logic              load_plain;
  logic              load_pair;
  logic [WORD_W-1:0] sum_plain;
  logic [WORD_W-1:0] sum_pair;

  assign in_ready   = !valid_q || out_ready;
  assign fire       = in_valid && in_ready;
  assign load_plain = fire && (state_q == ST_FETCH) && !dec.sentinel;
  assign load_pair  = fire && (state_q == ST_EXTWORD);
  assign step_one   = load_plain;
  assign step_two   = load_pair;
  assign sum_plain  = pc + dec.imm;
  assign sum_pair   = pc + in_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FETCH;
      hold_q   <= '0;
      valid_q  <= 1'b0;
      ext_q    <= 1'b0;
      beat_q   <= '0;
      pc_out_q <= '0;
      target_q <= '0;
    end else begin
      if (valid_q && out_ready)
        valid_q <= 1'b0;
      if (fire && state_q == ST_FETCH && dec.sentinel) begin
        hold_q  <= dec;
        state_q <= ST_EXTWORD;
      end
      if (load_plain) begin
        valid_q  <= 1'b1;
        ext_q    <= 1'b0;
        beat_q   <= dec;
        pc_out_q <= pc;
        target_q <= {sum_plain[WORD_W-1:1], 1'b0};
      end
      if (load_pair) begin
        valid_q    <= 1'b1;
        ext_q      <= 1'b1;
        beat_q     <= hold_q;
        beat_q.imm <= in_word;
        pc_out_q   <= pc;
        target_q   <= {sum_pair[WORD_W-1:1], 1'b0};
        state_q    <= ST_FETCH;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_ext    = ext_q;
  assign out_dec    = beat_q;
  assign out_pc     = pc_out_q;
  assign out_target = target_q;

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (rst)
    valid_q && !out_ready |=> valid_q && $stable(pc_out_q) && $stable(beat_q)
                              && $stable(ext_q) && $stable(target_q));
  assert_pending_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXTWORD) && !fire |=> (state_q == ST_EXTWORD) && $stable(hold_q));
  assert_ext_class_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q && ext_q |-> (beat_q.opcode == OPC_ALUI || beat_q.opcode == OPC_LOAD ||
                          beat_q.opcode == OPC_STORE || beat_q.opcode == OPC_BRANCH));
  assert_target_even_R8: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !target_q[0]);
  assert_pair_single_beat_R6: assert property (@(posedge clk) disable iff (rst)
    fire && (state_q == ST_FETCH) && dec.sentinel |=> !$rose(valid_q));

endmodule

// File: rtl/ximm_decoder.sv
module ximm_decoder
  import ximm_pkg::*;
#(
  parameter logic [31:0] START_PC   = 32'h0000_1000,
  parameter bit          EXT_ENABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_pc,
  output logic [6:0]  out_opcode,
  output logic [4:0]  out_rd,
  output logic [4:0]  out_rs1,
  output logic [4:0]  out_rs2,
  output logic [2:0]  out_funct3,
  output logic [31:0] out_imm,
  output logic [31:0] out_target,
  output logic        out_ext
);

  dec_t              word_dec;
  dec_t              beat;
  logic [WORD_W-1:0] pc_now;
  logic              step_one;
  logic              step_two;

  ximm_imm_extract #(.EXT_ENABLE(EXT_ENABLE)) u_extract (
    .word (in_word),
    .dec  (word_dec)
  );

  ximm_pc_reg #(.START_PC(START_PC)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .step_one (step_one),
    .step_two (step_two),
    .pc       (pc_now)
  );

  ximm_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .dec        (word_dec),
    .pc         (pc_now),
    .step_one   (step_one),
    .step_two   (step_two),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_pc     (out_pc),
    .out_dec    (beat),
    .out_target (out_target),
    .out_ext    (out_ext)
  );

  assign out_opcode = beat.opcode;
  assign out_rd     = beat.rd;
  assign out_rs1    = beat.rs1;
  assign out_rs2    = beat.rs2;
  assign out_funct3 = beat.funct3;
  assign out_imm    = beat.imm;

  assert_aligned_pc_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_pc[0]);

endmodule

// File: tb/ximm_decoder_test.sv
module ximm_decoder_test;

  localparam logic [31:0] START = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pc, out_imm, out_target;
  logic [6:0]  out_opcode;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic [2:0]  out_funct3;
  logic        out_ext;

  ximm_decoder #(.START_PC(START)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_opcode(out_opcode),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_funct3(out_funct3),
    .out_imm(out_imm), .out_target(out_target), .out_ext(out_ext)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] words[$];
  int idx = 0;
  int mode = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx12(input logic [11:0] v);
    return {{20{v[11]}}, v};
  endfunction

  function automatic logic [31:0] ref_imm(input logic [31:0] w);
    case (w[6:0])
      7'h13, 7'h03, 7'h67: return sx12(w[31:20]);
      7'h23: return sx12({w[31:25], w[11:7]});
      7'h63: return sx12({w[31], w[7], w[30:25], w[11:8]}) << 1;
      7'h37, 7'h17: return {w[31:12], 12'h000};
      7'h6f: return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit ref_sent(input logic [31:0] w);
    case (w[6:0])
      7'h13, 7'h03: return w[31:20] == 12'h800;
      7'h23: return {w[31:25], w[11:7]} == 12'h800;
      7'h63: return {w[31], w[7], w[30:25], w[11:8]} == 12'h800;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int kind, input bit sent, input logic [31:0] r);
    logic [31:0] w = r;
    logic [6:0] opcs[8] = '{7'h13, 7'h03, 7'h23, 7'h63, 7'h37, 7'h67, 7'h33, 7'h6f};
    w[6:0] = opcs[kind];
    if (sent) begin
      if (kind == 2) begin w[31:25] = 7'h40; w[11:7] = 5'h0; end
      else if (kind == 3) begin w[31] = 1'b1; w[7] = 1'b0; w[30:25] = '0; w[11:8] = '0; end
      else w[31:20] = 12'h800;
    end
    return w;
  endfunction

  // reference model state
  bit          m_valid = 0, m_wait = 0, m_gap = 0, m_first = 1;
  logic [31:0] m_hold, m_pc = START;
  logic [31:0] e_pc, e_imm, e_word;
  bit          e_ext;
  string       e_immtag, e_pctag;
  wire         m_ready = !m_valid || out_ready;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 0; m_wait <= 0; m_gap <= 0; m_first <= 1; m_pc <= START;
    end else begin
      if (m_valid && out_ready) m_valid <= 0;
      if (in_valid && m_ready) begin
        idx <= idx + 1;
        if (m_wait) begin
          m_valid <= 1; m_wait <= 0; e_word <= m_hold; e_imm <= in_word; e_ext <= 1;
          e_pc <= m_pc; m_pc <= m_pc + 8; m_first <= 0;
          e_immtag <= m_gap ? "R6/R10" : "R6";
          e_pctag <= m_first ? "R1" : "R7";
        end else if (ref_sent(in_word)) begin
          m_wait <= 1; m_hold <= in_word; m_gap <= 0;
        end else begin
          m_valid <= 1; e_word <= in_word; e_imm <= ref_imm(in_word); e_ext <= 0;
          e_pc <= m_pc; m_pc <= m_pc + 4; m_first <= 0;
          e_immtag <= (in_word[31:20] == 12'h800) ? "R9" : "R4";
          e_pctag <= m_first ? "R1" : "R7";
        end
      end else if (m_wait) m_gap <= 1;
    end
  end

  // compare, then drive, away from the active edge
  always @(negedge clk) begin
    chk({31'b0, in_ready}, {31'b0, m_ready}, "R2");
    chk({31'b0, out_valid}, {31'b0, m_valid}, rst ? "R1" : "R3");
    if (m_valid && !rst) begin
      chk(out_pc, e_pc, e_pctag);
      chk(out_imm, e_imm, e_immtag);
      chk({31'b0, out_ext}, {31'b0, e_ext}, "R5");
      chk(out_target, (e_pc + e_imm) & ~32'h1, "R8");
      chk({out_opcode, out_rd, out_funct3, out_rs1, out_rs2},
          {e_word[6:0], e_word[11:7], e_word[14:12], e_word[19:15], e_word[24:20]}, "R11");
    end
    in_valid  <= (idx < words.size()) && (mode == 0 || ($urandom % 4 != 0));
    in_word   <= (idx < words.size()) ? words[idx] : 32'hdead_beef;
    out_ready <= (mode == 0) || ($urandom % 3 != 0);
  end

  initial begin
    int cyc;
    void'($urandom(7));
    // directed
    words.push_back(mk(0, 0, 32'h07b0_0093));
    words.push_back(mk(0, 1, 32'h0000_0093));
    words.push_back(32'h1234_5678);
    words.push_back(mk(1, 1, 32'h0001_2103));
    words.push_back(mk(0, 1, 32'h0000_0013));          // extension word that is itself a sentinel opcode
    words.push_back(mk(2, 1, 32'h0020_a023));
    words.push_back(32'hffff_fff0);
    words.push_back(mk(3, 1, 32'h0020_8063));
    words.push_back(32'hffff_f001);                    // odd negative displacement
    words.push_back(mk(4, 1, 32'h0000_0537));
    words.push_back(mk(5, 1, 32'h0000_80e7));
    words.push_back(mk(6, 1, 32'h0020_8033));
    words.push_back(mk(2, 0, 32'hfe20_ae23));
    words.push_back(mk(3, 0, 32'hfe20_9ee3));
    words.push_back(mk(7, 0, 32'h8000_00ef));
    words.push_back(mk(0, 0, 32'h8000_0013));
    for (int i = 0; i < 400; i++)
      words.push_back(mk($urandom % 8, ($urandom % 3) == 0, $urandom));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (idx < 16 && cyc < 100000) begin @(negedge clk); cyc++; end
    mode = 1;
    while (!m_wait && cyc < 100000) begin @(negedge clk); cyc++; end
    rst = 1'b1;                                         // R1: reset with a half-consumed pair
    @(negedge clk);
    rst = 1'b0;
    while ((idx < words.size() || m_valid || m_wait) && cyc < 100000) begin
      @(negedge clk); cyc++;
      if (idx >= words.size() && m_wait) break;
    end
    repeat (4) @(negedge clk);
    if (cyc >= 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule